// File: doc/BRIEF.md
# Pulse Period and Width Measurement Timer

This block is a 16-bit timer that watches one digital input and works in one of two modes. In timer mode the counter runs freely. It copies its value into a capture register on a chosen edge of the input, and it raises a flag when it reaches a programmed compare value. In cycle measurement mode the counter restarts on every rising edge of the input. The block records the time from one rising edge to the next as the period, and the time from a rising edge to the following falling edge as the high width. Each recorded value is checked against programmable upper and lower limits.

Four sticky limit flags report a result out of range: period above its maximum, period below its minimum, width above its maximum and width below its minimum. When the stop-on-error control is set in cycle measurement mode, counting and recording freeze while any limit flag is raised. They resume once software has cleared the flags. The input passes through a two-stage synchronizer, so every edge takes effect on the third clock edge after the input changes.

Top module: `pulse_meter`

## Requirements
- R1: After reset the counter, the capture, period and width outputs and all six flags read zero.
- R2: While `start_i` is 0 the counter is held at zero, and the flags keep their values.
- R3: In timer mode (`cyc_mode_i`=0) with `start_i`=1, the counter advances by one every clock and wraps from 0xFFFF to 0x0000.
- R4: In timer mode the capture edge is rising when `edge_sel_i` XOR `pol_i` is 1 and falling otherwise. On that edge `cap_o` takes the count shown two clocks after the input changed, and flag bit 5 is set. The other edge changes neither.
- R5: In timer mode, flag bit 4 is set when the counter equals `cmp_i`.
- R6: In cycle mode the first rising edge after start only restarts the counter. Every later rising edge loads `period_o` with the number of clocks since the previous rising edge.
- R7: In cycle mode each falling edge that follows a rising edge loads `width_o` with the number of clocks the input was high.
- R8: Limit flags are bit 0 (period above `per_max_i`), bit 1 (period below `per_min_i`), bit 2 (width above `wid_max_i`) and bit 3 (width below `wid_min_i`). They are checked when a value is recorded. Bits 0 and 2 are also set as soon as the running count passes the maximum.
- R9: In cycle mode with `stop_err_i`=1, any raised limit flag freezes the counter, `period_o` and `width_o`. Counting resumes on the clock after the flags are cleared.
- R10: `edge_sel_i` and `pol_i` have no effect in cycle mode, `stop_err_i` has no effect in timer mode, `cap_o` holds in cycle mode, and limit flags are never set in timer mode.
- R11: Each flag stays set until a one-cycle pulse on its bit of `clr_i`. A set event in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run control; 0 holds the counter at zero |
| cyc_mode_i | input | 1 | 0 timer mode, 1 cycle measurement mode |
| edge_sel_i | input | 1 | Capture edge select for timer mode |
| pol_i | input | 1 | Inverts the meaning of edge_sel_i |
| stop_err_i | input | 1 | Freeze on limit error in cycle mode |
| sig_i | input | 1 | Measured asynchronous input |
| cmp_i | input | 16 | Compare value for timer mode |
| per_max_i | input | 16 | Period upper limit |
| per_min_i | input | 16 | Period lower limit |
| wid_max_i | input | 16 | Width upper limit |
| wid_min_i | input | 16 | Width lower limit |
| clr_i | input | 6 | Per-flag clear pulses |
| cnt_o | output | 16 | Counter value |
| cap_o | output | 16 | Timer-mode capture |
| period_o | output | 16 | Last recorded period |
| width_o | output | 16 | Last recorded high width |
| flags_o | output | 6 | Sticky flags: 0-3 limits, 4 compare, 5 capture |

## Verification
The assertions check on every cycle that the counter clears while idle, steps by one in timer mode and stays frozen during a stop-on-error halt. They also check that no flag drops without its clear bit, that limit flags stay quiet in timer mode, and that each mode leaves the other mode's result registers alone. The bench scenarios cover what depends on input history: the exact period and width values for random pulse trains, the flags expected from random limits, the edge-select and polarity combinations, the clear-versus-set collision, and the halt followed by resumption.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int NFLAG     = 6;
  localparam int F_POVR    = 0;
  localparam int F_PUND    = 1;
  localparam int F_WOVR    = 2;
  localparam int F_WUND    = 3;
  localparam int F_CMP     = 4;
  localparam int F_CAP     = 5;
  localparam int NLIM      = 2;   // index 0 period, 1 width
  localparam int LIM_PER   = 0;
  localparam int LIM_WID   = 1;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/pm_sync_edge.sv
module pm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              prev_q;
  logic              lvl;

  always_comb sh_d = {sh_q[STAGES-2:0], sig_i};
  assign lvl = sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= lvl;
    end
  end

  assign rise_o = lvl & ~prev_q;
  assign fall_o = ~lvl & prev_q;
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         hold_i,
  input  logic         restart_i,
  input  logic         sat_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)                    cnt_d = '0;
    else if (hold_i)               cnt_d = cnt_q;
    else if (restart_i)            cnt_d = W'(1);
    else if (sat_i && &cnt_q)      cnt_d = cnt_q;
    else                           cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pm_limit_chk.sv
module pm_limit_chk #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic         track_i,
  input  logic         latch_i,
  input  logic [W-1:0] max_i,
  input  logic [W-1:0] min_i,
  output logic         over_o,
  output logic         under_o
);
  logic run_over;
  logic rec_over;
  logic rec_under;

  always_comb begin
    run_over  = track_i && (cnt_i > max_i);
    rec_over  = latch_i && (cnt_i > max_i);
    rec_under = latch_i && (cnt_i < min_i);
    over_o    = run_over | rec_over;
    under_o   = rec_under;
  end
endmodule

// File: rtl/pm_flags.sv
module pm_flags #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] fl_q;
  logic [N-1:0] fl_d;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (set_i[i])      fl_d[i] = 1'b1;
      else if (clr_i[i]) fl_d[i] = 1'b0;
      else               fl_d[i] = fl_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= fl_d;
  end

  assign flags_o = fl_q;
endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
  import pm_pkg::*;
#(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cyc_mode_i,
  input  logic             edge_sel_i,
  input  logic             pol_i,
  input  logic             stop_err_i,
  input  logic             sig_i,
  input  logic [W-1:0]     cmp_i,
  input  logic [W-1:0]     per_max_i,
  input  logic [W-1:0]     per_min_i,
  input  logic [W-1:0]     wid_max_i,
  input  logic [W-1:0]     wid_min_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [W-1:0]     cnt_o,
  output logic [W-1:0]     cap_o,
  output logic [W-1:0]     period_o,
  output logic [W-1:0]     width_o,
  output logic [NFLAG-1:0] flags_o
);
  logic rst_q_n;
  logic rise, fall;
  logic halt, go;
  logic rise_ev, fall_ev, cap_ev, cmp_ev;
  logic per_latch, wid_latch;
  logic cap_rising;
  logic [W-1:0] cnt;
  logic [NFLAG-1:0] flags, flag_set;
  logic [NLIM-1:0] lim_track, lim_latch, lim_over, lim_under;
  logic [NLIM-1:0][W-1:0] lim_max, lim_min;

  logic armed_q, armed_d;
  logic hi_q, hi_d;
  logic [W-1:0] cap_q, cap_d;
  logic [W-1:0] per_q, per_d;
  logic [W-1:0] wid_q, wid_d;

  pm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  pm_sync_edge #(.STAGES(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_q_n), .sig_i(sig_i), .rise_o(rise), .fall_o(fall)
  );

  // halt only in cycle mode, only on limit flags
  always_comb begin
    halt       = start_i & cyc_mode_i & stop_err_i &
                 (flags[F_POVR] | flags[F_PUND] | flags[F_WOVR] | flags[F_WUND]);
    go         = start_i & ~halt;
    rise_ev    = go & cyc_mode_i & rise;
    fall_ev    = go & cyc_mode_i & fall;
    per_latch  = rise_ev & armed_q;
    wid_latch  = fall_ev & hi_q;
    cap_rising = edge_sel_i ^ pol_i;
    cap_ev     = go & ~cyc_mode_i & (cap_rising ? rise : fall);
    cmp_ev     = go & ~cyc_mode_i & (cnt == cmp_i);
  end

  pm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_q_n), .run_i(start_i), .hold_i(halt),
    .restart_i(rise_ev), .sat_i(cyc_mode_i), .cnt_o(cnt)
  );

  always_comb begin
    lim_track[LIM_PER] = go & cyc_mode_i & armed_q;
    lim_latch[LIM_PER] = per_latch;
    lim_max[LIM_PER]   = per_max_i;
    lim_min[LIM_PER]   = per_min_i;
    lim_track[LIM_WID] = go & cyc_mode_i & hi_q;
    lim_latch[LIM_WID] = wid_latch;
    lim_max[LIM_WID]   = wid_max_i;
    lim_min[LIM_WID]   = wid_min_i;
  end

  for (genvar k = 0; k < NLIM; k++) begin : g_lim
    pm_limit_chk #(.W(W)) u_chk (
      .cnt_i(cnt), .track_i(lim_track[k]), .latch_i(lim_latch[k]),
      .max_i(lim_max[k]), .min_i(lim_min[k]),
      .over_o(lim_over[k]), .under_o(lim_under[k])
    );
  end

  always_comb begin
    flag_set         = '0;
    flag_set[F_POVR] = lim_over[LIM_PER];
    flag_set[F_PUND] = lim_under[LIM_PER];
    flag_set[F_WOVR] = lim_over[LIM_WID];
    flag_set[F_WUND] = lim_under[LIM_WID];
    flag_set[F_CMP]  = cmp_ev;
    flag_set[F_CAP]  = cap_ev;
  end

  pm_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_q_n), .set_i(flag_set), .clr_i(clr_i), .flags_o(flags)
  );

  // next-state for measurement state and result registers
  always_comb begin
    armed_d = armed_q;
    hi_d    = hi_q;
    if (!start_i || !cyc_mode_i) begin
      armed_d = 1'b0;
      hi_d    = 1'b0;
    end else if (rise_ev) begin
      armed_d = 1'b1;
      hi_d    = 1'b1;
    end else if (fall_ev) begin
      hi_d    = 1'b0;
    end
    cap_d = cap_ev    ? cnt : cap_q;
    per_d = per_latch ? cnt : per_q;
    wid_d = wid_latch ? cnt : wid_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      armed_q <= 1'b0;
      hi_q    <= 1'b0;
      cap_q   <= '0;
      per_q   <= '0;
      wid_q   <= '0;
    end else begin
      armed_q <= armed_d;
      hi_q    <= hi_d;
      cap_q   <= cap_d;
      per_q   <= per_d;
      wid_q   <= wid_d;
    end
  end

  assign cnt_o    = cnt;
  assign cap_o    = cap_q;
  assign period_o = per_q;
  assign width_o  = wid_q;
  assign flags_o  = flags;
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int W = 16,
  parameter int N = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         cyc_mode_i,
  input logic         stop_err_i,
  input logic [N-1:0] clr_i,
  input logic [W-1:0] cnt_o,
  input logic [W-1:0] cap_o,
  input logic [W-1:0] period_o,
  input logic [W-1:0] width_o,
  input logic [N-1:0] flags_o
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> cnt_o == '0); // R2

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !cyc_mode_i) |=> cnt_o == W'($past(cnt_o) + W'(1))); // R3

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cyc_mode_i && stop_err_i && (|flags_o[3:0]))
      |=> ($stable(cnt_o) && $stable(period_o) && $stable(width_o))); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags_o) & ~$past(clr_i)) & ~flags_o) == '0)); // R11

  AST_NO_LIMIT_IN_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_mode_i |=> ((flags_o[3:0] & ~$past(flags_o[3:0])) == 4'b0)); // R10

  AST_CAP_HOLD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_mode_i |=> $stable(cap_o)); // R10

  AST_MEAS_HOLD_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_mode_i |=> ($stable(period_o) && $stable(width_o))); // R6
endmodule

bind pulse_meter pm_checker #(.W(W), .N(pm_pkg::NFLAG)) u_pm_checker (
  .clk(clk), .rst_n(rst_q_n), .start_i(start_i), .cyc_mode_i(cyc_mode_i),
  .stop_err_i(stop_err_i), .clr_i(clr_i), .cnt_o(cnt_o), .cap_o(cap_o),
  .period_o(period_o), .width_o(width_o), .flags_o(flags_o)
);

// File: tb/pulse_meter_tb_top.sv
module pulse_meter_tb_top;
  localparam int  W      = 16;
  localparam time CLK_PD = 10;

  logic clk = 1'b0;
  logic rst_n, start, cyc, esel, pol, stop, sig;
  logic [W-1:0] cmp, pmax, pmin, wmax, wmin;
  logic [5:0] clr;
  logic [W-1:0] cnt_o, cap_o, period_o, width_o;
  logic [5:0] flags_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PD/2) clk = ~clk;

  pulse_meter #(.W(W), .SYNC(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cyc_mode_i(cyc),
    .edge_sel_i(esel), .pol_i(pol), .stop_err_i(stop), .sig_i(sig),
    .cmp_i(cmp), .per_max_i(pmax), .per_min_i(pmin), .wid_max_i(wmax),
    .wid_min_i(wmin), .clr_i(clr), .cnt_o(cnt_o), .cap_o(cap_o),
    .period_o(period_o), .width_o(width_o), .flags_o(flags_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [3:0] exp_lim(int p, int h, int pmx, int pmn, int wmx, int wmn);
    logic [3:0] e;
    e[0] = p > pmx;
    e[1] = p < pmn;
    e[2] = h > wmx;
    e[3] = h < wmn;
    return e;
  endfunction

  task automatic clear_all();
    clr = 6'h3F; tick(); clr = 6'h00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      summary();
    end
  end

  initial begin
    int unsigned seed;
    logic [W-1:0] c0, capb, pv, wv;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; start = 0; cyc = 0; esel = 0; pol = 0; stop = 0; sig = 0;
    cmp = '1; pmax = '1; pmin = '0; wmax = '1; wmin = '0; clr = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1 reset state
    check(cnt_o == 0 && cap_o == 0 && period_o == 0 && width_o == 0 && flags_o == 0,
          "R1 reset", {cnt_o, flags_o}, 0);
    // R2 idle with input toggling
    sig = 1; repeat (4) tick(); sig = 0; repeat (4) tick();
    check(cnt_o == 0, "R2 idle counter", cnt_o, 0);

    // R3 timer counting
    start = 1;
    repeat (7) tick();
    check(cnt_o == 7, "R3 timer step", cnt_o, 7);

    // R4 capture edge combinations
    for (int k = 0; k < 4; k++) begin
      bit rising;
      esel = k[0]; pol = k[1]; rising = esel ^ pol;
      repeat (4) tick(); clear_all();
      for (int e = 0; e < 2; e++) begin
        capb = cap_o;
        sig = ~sig; c0 = cnt_o;
        repeat (5) tick();
        if (sig == rising)
          check(cap_o == W'(c0 + 2) && flags_o[5], "R4 capture taken", cap_o, W'(c0 + 2));
        else
          check(cap_o == capb && !flags_o[5], "R4 capture ignored", cap_o, capb);
        clear_all();
      end
    end

    // R11 set wins over clear in the same cycle
    esel = 1; pol = 0; sig = 0; repeat (4) tick(); clear_all();
    sig = 1; tick(); tick(); clr = 6'h20; tick(); clr = 0; tick(); tick();
    check(flags_o[5] == 1'b1, "R11 set over clear", flags_o[5], 1);
    clear_all();

    // R5 compare match
    c0 = cnt_o; cmp = W'(c0 + 10);
    repeat (8) tick();
    check(flags_o[4] == 1'b0, "R5 compare early", flags_o[4], 0);
    repeat (5) tick();
    check(flags_o[4] == 1'b1, "R5 compare hit", flags_o[4], 1);
    cmp = '1; clear_all();

    // R6 R7 R8 R10 random pulse trains in cycle mode
    sig = 0;
    for (int b = 0; b < 5; b++) begin
      int pmx, pmn, wmx, wmn, pp, ph;
      pmx = 20 + int'($urandom % 71); pmn = 5 + int'($urandom % 56);
      wmx = 8 + int'($urandom % 38);  wmn = 3 + int'($urandom % 28);
      pmax = W'(pmx); pmin = W'(pmn); wmax = W'(wmx); wmin = W'(wmn);
      start = 0; stop = 0; tick(); cyc = 1;
      esel = 1'($urandom % 2); pol = 1'($urandom % 2);
      start = 1; clear_all(); tick();
      pp = 0; ph = 0;
      for (int i = 0; i < 7; i++) begin
        int h, l;
        h = 6 + int'($urandom % 35); l = 2 + int'($urandom % 39);
        sig = 1;
        repeat (4) tick();
        if (i > 0) begin
          check(period_o == W'(pp), "R6 period", period_o, pp);
          check(width_o == W'(ph), "R7 width", width_o, ph);
          check(flags_o == {2'b00, exp_lim(pp, ph, pmx, pmn, wmx, wmn)},
                "R8 limit flags (R10 edge/pol ignored)", flags_o,
                {2'b00, exp_lim(pp, ph, pmx, pmn, wmx, wmn)});
        end
        clear_all();
        repeat (h - 5) tick();
        sig = 0;
        repeat (l) tick();
        pp = h + l; ph = h;
      end
    end

    // R9 stop-on-error halt
    start = 0; tick(); cyc = 1; stop = 1;
    pmax = 20; pmin = 0; wmax = '1; wmin = 0; sig = 0;
    start = 1; clear_all();
    pv = period_o; wv = width_o;
    sig = 1; repeat (40) tick();
    check(cnt_o == 22, "R9 halted count", cnt_o, 22);
    check(flags_o == 6'h01, "R9 halt flag", flags_o, 1);
    sig = 0; repeat (6) tick(); sig = 1; repeat (6) tick();
    check(cnt_o == 22 && period_o == pv && width_o == wv, "R9 frozen results",
          {period_o, width_o}, {pv, wv});

    // R10 stop-on-error ignored in timer mode, R11 and R2 flags kept
    start = 0; tick(); cyc = 0; start = 1;
    repeat (5) tick();
    check(cnt_o == 5, "R10 timer ignores stop", cnt_o, 5);
    check(flags_o[0] == 1'b1, "R11 flag kept over start", flags_o[0], 1);

    // R9 resume after clear
    start = 0; tick(); cyc = 1; start = 1;
    repeat (3) tick();
    check(cnt_o == 0, "R9 halted at start", cnt_o, 0);
    clr = 6'h01; tick(); clr = 0;
    repeat (4) tick();
    check(cnt_o == 4, "R9 resume", cnt_o, 4);

    // R3 wrap in timer mode
    start = 0; stop = 0; tick(); cyc = 0; start = 1;
    c0 = cnt_o;
    repeat (65536) tick();
    check(cnt_o == c0, "R3 wrap", cnt_o, c0);

    done = 1;
    summary();
  end
endmodule